// File: doc/BRIEF.md
# Compare-Triggered Pattern Output Port

This block is a 16-pin double-buffered pattern output port. Software places the next pattern in a pair of 8-bit shadow ("next") registers. The port data register drives the pins. When a timer compare-match pulse arrives, the shadow bits that are enabled for pattern output are copied into the port data register in a single step. A pattern of up to 16 bits can therefore change on every compare match, as long as software refills the shadow registers between matches.

Each pin has a direction bit and a pattern-enable bit, and the pair gives the pin one of four functions:

| Direction | Pattern enable | Pin function |
|-----------|----------------|--------------|
| 0 | 0 | plain input |
| 1 | 0 | plain output from the data register |
| 0 | 1 | input whose data bit is locked against bus writes but still reloaded on compare match |
| 1 | 1 | pattern output that changes on compare match |

The pins form four groups of four. Each group chooses its own compare-match trigger through a select field. The timer that produces the compare-match pulses is not part of this block.

The block has no state machine. Every pin's behaviour follows from its two configuration bits and the per-group trigger.

Top module: `pattern_port`

## Requirements
- R1: After reset the following all read 0: the direction, enable and next registers (addresses 0 to 5), `pin_oe` and `pin_out`. A read of address 6 or 7 after reset returns `pin_in[7:0]` or `pin_in[15:8]`.
- R2: The register map is as follows, where "low" means pins 7:0 and "high" means pins 15:8:
  - address 0: direction, low
  - address 1: direction, high
  - address 2: pattern enable, low
  - address 3: pattern enable, high
  - address 4: next data, low
  - address 5: next data, high
  - address 6: port data, low
  - address 7: port data, high

  Addresses 0 to 5 read back the value last written. A register write takes effect at the clock edge where `bus_we` is high.
- R3: A pin with direction 0 and enable 0 is an input: its `pin_oe` bit is 0 and a read of its data bit returns `pin_in`. A bus write to its data bit is still stored, and the stored value is seen on `pin_out`.
- R4: A pin with direction 1 and enable 0 is an output: its `pin_oe` bit is 1, and `pin_out` and the read value both show the data bit. The data bit follows bus writes, and compare matches leave it unchanged.
- R5: A pin with direction 0 and enable 1 is an input whose data bit ignores bus writes. On each compare match of its group, the data bit takes the next-data bit, and `pin_out` shows the change.
- R6: A pin with direction 1 and enable 1 drives `pin_out` from its data bit with `pin_oe` at 1. The data bit takes the next-data value on its group's compare match.
- R7: `cm_pulse` is sampled at a clock edge. If the selected pulse is high at edge k, the data bits change at edge k+1. Without a selected pulse, the enabled data bits stay unchanged.
- R8: Group g covers pins 4g+3:4g and is triggered by `cm_pulse[trig_sel[2g+1:2g]]`. Groups 0 and 1 take their next data from address 4, and groups 2 and 3 from address 5. A pulse on a trigger that no group selects changes nothing.
- R9: When new next data is written between compare matches, successive matches output successive patterns, one per match.
- R10: A bus write to a data register that takes effect in the same cycle as a compare-match transfer is resolved bit by bit. Enabled bits take the next data, and non-enabled bits take the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on `bus_addr`) |
| cm_pulse | input | 4 | Compare-match pulses from the timer |
| trig_sel | input | 8 | Per-group trigger select, two bits per group |
| pin_in | input | 16 | Pin levels |
| pin_out | output | 16 | Pin output values (the data register) |
| pin_oe | output | 16 | Pin output enables (the direction register) |

## Verification
The bench sweeps every pin function, both as uniform settings and as per-bit mixtures, while a model in the bench predicts every port.

It probes the following corner cases:
- **Transfer latency.** It checks that nothing moves in the cycle after the pulse is sampled. A design without the trigger stage would update one cycle early.
- **Write lock on enabled bits.** A design that lets bus writes reach enabled bits would corrupt locked inputs.
- **Trigger routing.** Single pulses are steered to each group separately. Mis-indexed selects or swapped next-data halves would update the wrong pins.
- **Write and transfer in the same cycle.** A design with the wrong priority would lose either the written bits or the pattern bits.

// File: rtl/pport_pkg.sv
package pport_pkg;

    typedef enum logic [2:0] {
        RA_DIR_LO  = 3'd0,
        RA_DIR_HI  = 3'd1,
        RA_EN_LO   = 3'd2,
        RA_EN_HI   = 3'd3,
        RA_NXT_LO  = 3'd4,
        RA_NXT_HI  = 3'd5,
        RA_DATA_LO = 3'd6,
        RA_DATA_HI = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int PORT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] en_q,
    output logic [PORT_W-1:0] nxt_q,
    output logic [1:0]        data_wr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            en_q  <= '0;
            nxt_q <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                RA_DIR_LO: dir_q[HALF_W-1:0]      <= wdata;
                RA_DIR_HI: dir_q[PORT_W-1:HALF_W] <= wdata;
                RA_EN_LO:  en_q[HALF_W-1:0]       <= wdata;
                RA_EN_HI:  en_q[PORT_W-1:HALF_W]  <= wdata;
                RA_NXT_LO: nxt_q[HALF_W-1:0]      <= wdata;
                RA_NXT_HI: nxt_q[PORT_W-1:HALF_W] <= wdata;
                default: ;
            endcase
        end
    end

    assign data_wr[0] = we && (reg_addr_e'(addr) == RA_DATA_LO);
    assign data_wr[1] = we && (reg_addr_e'(addr) == RA_DATA_HI);

    // R2: configuration holds when no write is presented
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(dir_q) && $stable(en_q) && $stable(nxt_q)));

endmodule

// File: rtl/pport_group.sv
module pport_group #(
    parameter int GW    = 4,
    parameter int NTRIG = 4,
    parameter int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] cm_q,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_stb,
    input  logic [GW-1:0]    wdata,
    input  logic [GW-1:0]    en,
    input  logic [GW-1:0]    nxt,
    output logic [GW-1:0]    data_q
);

    logic          fire;
    logic [GW-1:0] data_d;

    assign fire = cm_q[sel];

    always_comb begin
        data_d = data_q;
        if (wr_stb) data_d = (data_q & en) | (wdata & ~en);
        if (fire)   data_d = (data_d & ~en) | (nxt & en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    // R6 / R10: enabled bits take the next data on a transfer
    a_r6_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (((data_q ^ $past(nxt)) & $past(en)) == '0));

    // R5 / R7: enabled bits do not move without a transfer
    a_r7_no_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (((data_q ^ $past(data_q)) & $past(en)) == '0));

    // R4: non-enabled bits ignore the transfer and change only on a write
    a_r4_plain_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> (((data_q ^ $past(data_q)) & ~$past(en)) == '0));

endmodule

// File: rtl/pattern_port.sv
module pattern_port
    import pport_pkg::*;
#(
    parameter int GROUP_W    = 4,
    parameter int NUM_GROUPS = 4,
    parameter int NUM_TRIG   = 4,
    localparam int PORT_W    = GROUP_W * NUM_GROUPS,
    localparam int HALF_W    = PORT_W / 2,
    localparam int GPH       = NUM_GROUPS / 2,
    localparam int SEL_W     = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  bus_addr,
    input  logic                        bus_we,
    input  logic [HALF_W-1:0]           bus_wdata,
    output logic [HALF_W-1:0]           bus_rdata,
    input  logic [NUM_TRIG-1:0]         cm_pulse,
    input  logic [NUM_GROUPS*SEL_W-1:0] trig_sel,
    input  logic [PORT_W-1:0]           pin_in,
    output logic [PORT_W-1:0]           pin_out,
    output logic [PORT_W-1:0]           pin_oe
);

    logic [PORT_W-1:0]   dir_q, en_q, nxt_q, data_q, data_view;
    logic [1:0]          data_wr;
    logic [NUM_TRIG-1:0] cm_q;

    pport_regs #(.HALF_W(HALF_W), .PORT_W(PORT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .en_q   (en_q),
        .nxt_q  (nxt_q),
        .data_wr(data_wr)
    );

    // Trigger sampling stage: pulse seen at edge k, transfer at edge k+1
    always_ff @(posedge clk) begin
        if (!rst_n) cm_q <= '0;
        else        cm_q <= cm_pulse;
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int HALF = g / GPH;
        localparam int OFS  = (g % GPH) * GROUP_W;
        pport_group #(.GW(GROUP_W), .NTRIG(NUM_TRIG), .SEL_W(SEL_W)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .cm_q  (cm_q),
            .sel   (trig_sel[g*SEL_W +: SEL_W]),
            .wr_stb(data_wr[HALF]),
            .wdata (bus_wdata[OFS +: GROUP_W]),
            .en    (en_q[g*GROUP_W +: GROUP_W]),
            .nxt   (nxt_q[g*GROUP_W +: GROUP_W]),
            .data_q(data_q[g*GROUP_W +: GROUP_W])
        );
    end

    assign data_view = (dir_q & data_q) | (~dir_q & pin_in);
    assign pin_out   = data_q;
    assign pin_oe    = dir_q;

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            RA_DIR_LO:  bus_rdata = dir_q[HALF_W-1:0];
            RA_DIR_HI:  bus_rdata = dir_q[PORT_W-1:HALF_W];
            RA_EN_LO:   bus_rdata = en_q[HALF_W-1:0];
            RA_EN_HI:   bus_rdata = en_q[PORT_W-1:HALF_W];
            RA_NXT_LO:  bus_rdata = nxt_q[HALF_W-1:0];
            RA_NXT_HI:  bus_rdata = nxt_q[PORT_W-1:HALF_W];
            RA_DATA_LO: bus_rdata = data_view[HALF_W-1:0];
            RA_DATA_HI: bus_rdata = data_view[PORT_W-1:HALF_W];
            default:    bus_rdata = '0;
        endcase
    end

    // R1: leaving reset, every pin is an undriven input holding zero
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

endmodule

// File: tb/tb_pattern_port.sv
module tb_pattern_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  cm_pulse = '0;
    logic [7:0]  trig_sel = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [15:0] mdir, men, mnext, mdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    pattern_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cm_pulse(cm_pulse),
        .trig_sel(trig_sel), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mix(int i);
        logic [15:0] v;
        v = 16'(i * 16'h9E37) ^ 16'(i << 7) ^ 16'h5A1C;
        return v;
    endfunction

    // Bench model of a data-register write (enabled bits locked)
    function automatic void model_data_write(int half, logic [7:0] d);
        logic [7:0] e, old;
        e   = men[half*8 +: 8];
        old = mdata[half*8 +: 8];
        mdata[half*8 +: 8] = (old & e) | (d & ~e);
    endfunction

    function automatic void model_write(logic [2:0] a, logic [7:0] d);
        case (a)
            3'd0: mdir[7:0]   = d;
            3'd1: mdir[15:8]  = d;
            3'd2: men[7:0]    = d;
            3'd3: men[15:8]   = d;
            3'd4: mnext[7:0]  = d;
            3'd5: mnext[15:8] = d;
            3'd6: model_data_write(0, d);
            default: model_data_write(1, d);
        endcase
    endfunction

    function automatic void model_fire(logic [3:0] mask);
        for (int g = 0; g < 4; g++) begin
            if (mask[trig_sel[2*g +: 2]]) begin
                logic [15:0] m;
                m = men & (16'hF << (4*g));
                mdata = (mdata & ~m) | (mnext & m);
            end
        end
    endfunction

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all(string req);
        logic [7:0] lo, hi;
        logic [15:0] view;
        view = (mdir & mdata) | (~mdir & pin_in);
        chk({req, " pin_out"}, pin_out, mdata);
        chk({req, " pin_oe"}, pin_oe, mdir);
        rd(3'd6, lo);
        rd(3'd7, hi);
        chk({req, " read data"}, {hi, lo}, view);
    endtask

    // Compare-match pulse; optional bus write landing with the transfer
    task automatic pulse(logic [3:0] mask, bit collide, logic [2:0] a, logic [7:0] d, string req);
        @(negedge clk);
        cm_pulse = mask;
        @(negedge clk);
        cm_pulse = '0;
        chk({req, " R7 no early change"}, pin_out, mdata);
        if (collide) begin
            bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        end
        @(negedge clk);
        bus_we = 1'b0;
        if (collide) model_write(a, d);
        model_fire(mask);
        check_all(req);
    endtask

    initial begin
        logic [7:0] r;
        mdir = '0; men = '0; mnext = '0; mdata = '0;
        pin_in = 16'hA5C3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), r);
            chk("R1 cfg reg zero", {8'h0, r}, 16'h0);
        end
        check_all("R1");

        // R2: register readback
        wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h56);
        wr(3'd3, 8'h78); wr(3'd4, 8'h9A); wr(3'd5, 8'hBC);
        rd(3'd0, r); chk("R2 dir lo", {8'h0, r}, 16'h12);
        rd(3'd1, r); chk("R2 dir hi", {8'h0, r}, 16'h34);
        rd(3'd2, r); chk("R2 en lo", {8'h0, r}, 16'h56);
        rd(3'd3, r); chk("R2 en hi", {8'h0, r}, 16'h78);
        rd(3'd4, r); chk("R2 next lo", {8'h0, r}, 16'h9A);
        rd(3'd5, r); chk("R2 next hi", {8'h0, r}, 16'hBC);

        // R3 R4 R5 R6: uniform sweep over all four pin functions
        trig_sel = 8'h00;
        for (int m = 0; m < 4; m++) begin
            logic [7:0] dv, ev;
            dv = m[0] ? 8'hFF : 8'h00;
            ev = m[1] ? 8'hFF : 8'h00;
            wr(3'd0, dv); wr(3'd1, dv); wr(3'd2, ev); wr(3'd3, ev);
            for (int p = 0; p < 6; p++) begin
                logic [15:0] nv, dw;
                nv = mix(p + 8*m);
                dw = mix(p + 40);
                pin_in = mix(p + 90);
                wr(3'd4, nv[7:0]); wr(3'd5, nv[15:8]);
                wr(3'd6, dw[7:0]); wr(3'd7, dw[15:8]);
                case (m)
                    0: check_all("R3 input after write");
                    1: check_all("R4 output after write");
                    2: check_all("R5 locked input after write");
                    default: check_all("R6 pattern after write");
                endcase
                case (m)
                    0: pulse(4'h1, 1'b0, 3'd0, 8'h0, "R3 input match");
                    1: pulse(4'h1, 1'b0, 3'd0, 8'h0, "R4 output match");
                    2: pulse(4'h1, 1'b0, 3'd0, 8'h0, "R5 locked match");
                    default: pulse(4'h1, 1'b0, 3'd0, 8'h0, "R6 pattern match");
                endcase
            end
        end

        // R3 R4 R5 R6: per-bit mixed functions
        for (int i = 0; i < 24; i++) begin
            logic [15:0] dv, ev, nv, dw;
            dv = mix(3*i + 1); ev = mix(5*i + 2);
            nv = mix(7*i + 3); dw = mix(11*i + 4);
            pin_in = mix(13*i + 5);
            wr(3'd0, dv[7:0]); wr(3'd1, dv[15:8]);
            wr(3'd2, ev[7:0]); wr(3'd3, ev[15:8]);
            wr(3'd4, nv[7:0]); wr(3'd5, nv[15:8]);
            wr(3'd6, dw[7:0]); wr(3'd7, dw[15:8]);
            check_all("R3 R4 R5 mixed write");
            pulse(4'h1, 1'b0, 3'd0, 8'h0, "R6 mixed match");
        end

        // R7: no pulse, no change over idle cycles
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd4, 8'h3C); wr(3'd5, 8'hE1);
        repeat (5) @(negedge clk);
        check_all("R7 idle hold");

        // R8: group routing with distinct selects
        trig_sel = {2'd0, 2'd1, 2'd2, 2'd3};
        for (int t = 0; t < 4; t++) begin
            logic [15:0] nv;
            nv = mix(200 + t);
            wr(3'd4, nv[7:0]); wr(3'd5, nv[15:8]);
            pulse(4'(1 << t), 1'b0, 3'd0, 8'h0, "R8 group routing");
        end
        trig_sel = 8'h00;
        wr(3'd4, 8'h77); wr(3'd5, 8'h88);
        pulse(4'hE, 1'b0, 3'd0, 8'h0, "R8 unselected trigger");

        // R9: sequential patterns
        for (int s = 0; s < 16; s++) begin
            logic [15:0] nv;
            nv = 16'(16'h0001 << s) ^ 16'(s * 16'h0111);
            wr(3'd4, nv[7:0]); wr(3'd5, nv[15:8]);
            pulse(4'h1, 1'b0, 3'd0, 8'h0, "R9 sequence");
            chk("R9 step value", pin_out, nv);
        end

        // R10: write and transfer in the same cycle
        wr(3'd2, 8'h0F); wr(3'd3, 8'hF0);
        wr(3'd4, 8'hA5); wr(3'd5, 8'h5A);
        pulse(4'h1, 1'b1, 3'd6, 8'hC3, "R10 collision lo");
        pulse(4'h1, 1'b1, 3'd7, 8'h3C, "R10 collision hi");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule